// File: doc/BRIEF.md
# Scanned Key Matrix Encoder with Key Queue

This block walks an 8-by-8 key switch matrix one row at a time. It drives a single row line high, waits a few clock cycles, and then samples the eight column return lines. It keeps the first closed switch found in each full pass over the matrix. A small debounce state machine confirms a key only when the same key leads two consecutive passes. Each confirmed key is turned into a 6-bit code and pushed into an eight-entry queue. The CPU reads that queue through a one-byte read port.

The read port has two views. The data view pops the oldest code. The status view returns the number of queued codes and a sticky overrun bit. The overrun bit is set when a confirmed key arrives while the queue is full. The interrupt line stays high as long as at least one code waits in the queue. A one-cycle clear pulse resets the overrun bit.

The debounce machine has three states. DB_IDLE means no key is being tracked. DB_PEND means one pass has seen a candidate key. DB_HELD means a key was confirmed and is still closed. The checks below run at the end of each full pass.
- In DB_IDLE, a closed key moves the machine to DB_PEND and records the key; with no key it stays in DB_IDLE.
- In DB_PEND, if the same key is seen again, the machine pushes the code and moves to DB_HELD. If a different key is seen, it stays in DB_PEND and tracks the new key. If no key is seen, it returns to DB_IDLE.
- In DB_HELD, the same key keeps the machine in DB_HELD. A different key moves it to DB_PEND. A pass with no key returns it to DB_IDLE.

Top module: `kbd_scan_fifo`

## Requirements
- R1: Exactly one bit of `row_drv` is high at any time (active high). Rows are selected in ascending order 0 to 7 and the order wraps after row 7. Each row stays selected for DWELL clock cycles (4 by default).
- R2: A key at row r, column c (a high on `col_in[c]` while row r is driven) has code r*8+c. The row index is in bits 5:3 and the column index in bits 2:0. A data read returns the code in `rd_data[5:0]` with bits 7:6 zero.
- R3: A key is queued only after it has been the leading key of two consecutive full passes. A key closed during only one pass queues nothing.
- R4: A key held closed for many passes is queued once. After one pass with no key closed, the same key can be queued again.
- R5: When several keys are closed, the lowest code leads the pass and only that code is queued. If that key then opens while another stays closed, the remaining key is queued after its own debounce.
- R6: The queue holds up to 8 codes and returns them oldest first. A data read (`rd_en` high with `rd_sel` low) pops one code.
- R7: A key confirmed while 8 codes are queued is discarded and sets the overrun bit. The overrun bit stays set until a `clr_ovr` pulse. The clear pulse leaves the queued codes and the count unchanged.
- R8: A status read (`rd_sel` high) returns the count in bits 3:0, the overrun bit in bit 7, and zeros in bits 6:4. A status read pops nothing.
- R9: `irq` is high exactly when the queue count is non-zero.
- R10: A data read while the queue is empty returns 0 and leaves the count at 0.
- R11: During and right after reset, `row_drv` selects row 0, the status byte is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_drv | output | 8 | One-hot row select, active high |
| col_in | input | 8 | Column return lines, high = switch closed on the driven row |
| rd_en | input | 1 | Read strobe; pops one code when `rd_sel` is low |
| rd_sel | input | 1 | 0 = data view, 1 = status view |
| rd_data | output | 8 | Combinational read data for the selected view |
| clr_ovr | input | 1 | One-cycle pulse that clears the overrun bit |
| irq | output | 1 | High while codes are queued |

## Verification
The bench walks every one of the 64 key positions and checks the code each one produces. A wrong row/column packing or a swapped field would show up as a bad code in the sweep.

It lines a press up so that the key is closed during exactly one pass. A design that confirms on a single sighting would queue that press. It also holds a key for a dozen passes; a design that does not wait for a release would queue it repeatedly.

Two keys are pressed together, and then the lower one is released. A design with the wrong priority would queue the higher code first. A design that stays locked after the first key would never report the second one.

Nine keys are queued without any reads. The bench then checks the 0x88 status byte, confirms the oldest-first order, and checks that the clear pulse leaves the queue untouched. A design that overwrites a queued entry or drops the sticky bit early would fail these checks.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    typedef enum logic [1:0] {
        DB_IDLE = 2'd0,
        DB_PEND = 2'd1,
        DB_HELD = 2'd2
    } db_state_e;

    localparam int RD_W = 8;
endpackage

// File: rtl/kbd_scanner.sv
module kbd_scanner #(
    parameter  int ROWS  = 8,
    parameter  int COLS  = 8,
    parameter  int DWELL = 4,
    localparam int RW    = $clog2(ROWS),
    localparam int CW    = $clog2(COLS),
    localparam int KW    = RW + CW,
    localparam int DW    = $clog2(DWELL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] col_in,
    output logic [ROWS-1:0] row_drv,
    output logic            scan_end,
    output logic            cand_valid,
    output logic [KW-1:0]   cand_code
);
    // DWELL must be at least 3 so the two-stage synchronizer settles within a row.
    logic [RW-1:0]   row_idx;
    logic [DW-1:0]   dwell_cnt;
    logic [COLS-1:0] col_s1, col_s2;
    logic            acc_valid;
    logic [KW-1:0]   acc_code;
    logic            sample;
    logic            row_hit;
    logic [CW-1:0]   row_col;

    assign sample   = (dwell_cnt == DW'(DWELL - 1));
    assign scan_end = sample && (row_idx == RW'(ROWS - 1));

    // lowest closed column in the row being sampled
    always_comb begin
        row_hit = 1'b0;
        row_col = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (col_s2[c]) begin
                row_hit = 1'b1;
                row_col = CW'(c);
            end
        end
    end

    // earlier rows win; within a row the lowest column wins
    always_comb begin
        cand_valid = acc_valid || (sample && row_hit);
        cand_code  = acc_valid ? acc_code : {row_idx, row_col};
    end

    always_comb begin
        row_drv          = '0;
        row_drv[row_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_idx   <= '0;
            dwell_cnt <= '0;
            col_s1    <= '0;
            col_s2    <= '0;
            acc_valid <= 1'b0;
            acc_code  <= '0;
        end else begin
            col_s1 <= col_in;
            col_s2 <= col_s1;
            if (sample) begin
                dwell_cnt <= '0;
                row_idx   <= scan_end ? '0 : row_idx + 1'b1;
                if (scan_end) begin
                    acc_valid <= 1'b0;
                end else begin
                    acc_valid <= cand_valid;
                    acc_code  <= cand_code;
                end
            end else begin
                dwell_cnt <= dwell_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/kbd_debounce.sv
module kbd_debounce
    import kbd_pkg::*;
#(
    parameter int KW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_end,
    input  logic          cand_valid,
    input  logic [KW-1:0] cand_code,
    output logic          push,
    output logic [KW-1:0] push_code
);
    db_state_e     state, nxt;
    logic [KW-1:0] pend_code;
    logic          same_key;

    assign same_key = cand_valid && (cand_code == pend_code);

    always_comb begin
        nxt = state;
        if (scan_end) begin
            unique case (state)
                DB_IDLE: nxt = cand_valid ? DB_PEND : DB_IDLE;
                DB_PEND: nxt = same_key ? DB_HELD : (cand_valid ? DB_PEND : DB_IDLE);
                DB_HELD: nxt = same_key ? DB_HELD : (cand_valid ? DB_PEND : DB_IDLE);
                default: nxt = DB_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= DB_IDLE;
            pend_code <= '0;
        end else begin
            state <= nxt;
            if (scan_end && cand_valid) pend_code <= cand_code;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push      <= 1'b0;
            push_code <= '0;
        end else begin
            push      <= scan_end && (state == DB_PEND) && same_key;
            push_code <= pend_code;
        end
    end
endmodule

// File: rtl/kbd_fifo.sv
module kbd_fifo #(
    parameter  int DEPTH = 8,
    parameter  int WIDTH = 6,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [WIDTH-1:0] push_data,
    input  logic            pop,
    input  logic            clr_ovr,
    output logic [WIDTH-1:0] head,
    output logic [CNTW-1:0] count,
    output logic            ovr
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             pop_ok, push_ok;

    assign pop_ok  = pop && (count != '0);
    assign push_ok = push && ((count != CNTW'(DEPTH)) || pop_ok);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovr    <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && !push_ok) ovr <= 1'b1;
            else if (clr_ovr)     ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/kbd_scan_fifo.sv
module kbd_scan_fifo #(
    parameter  int ROWS  = 8,
    parameter  int COLS  = 8,
    parameter  int DWELL = 4,
    parameter  int DEPTH = 8,
    localparam int KW    = $clog2(ROWS) + $clog2(COLS),
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [ROWS-1:0] row_drv,
    input  logic [COLS-1:0] col_in,
    input  logic            rd_en,
    input  logic            rd_sel,
    output logic [7:0]      rd_data,
    input  logic            clr_ovr,
    output logic            irq
);
    logic            scan_end, cand_valid;
    logic [KW-1:0]   cand_code;
    logic            db_push;
    logic [KW-1:0]   db_code;
    logic [KW-1:0]   fifo_head;
    logic [CNTW-1:0] fifo_cnt;
    logic            fifo_ovr;
    logic            fifo_pop;

    assign fifo_pop = rd_en && !rd_sel;
    assign irq      = (fifo_cnt != '0);

    kbd_scanner #(.ROWS(ROWS), .COLS(COLS), .DWELL(DWELL)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .col_in     (col_in),
        .row_drv    (row_drv),
        .scan_end   (scan_end),
        .cand_valid (cand_valid),
        .cand_code  (cand_code)
    );

    kbd_debounce #(.KW(KW)) u_deb (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_end   (scan_end),
        .cand_valid (cand_valid),
        .cand_code  (cand_code),
        .push       (db_push),
        .push_code  (db_code)
    );

    kbd_fifo #(.DEPTH(DEPTH), .WIDTH(KW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (db_push),
        .push_data (db_code),
        .pop       (fifo_pop),
        .clr_ovr   (clr_ovr),
        .head      (fifo_head),
        .count     (fifo_cnt),
        .ovr       (fifo_ovr)
    );

    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            rd_data[7]        = fifo_ovr;
            rd_data[CNTW-1:0] = fifo_cnt;
        end else if (fifo_cnt != '0) begin
            rd_data[KW-1:0] = fifo_head;
        end
    end
endmodule

// File: rtl/kbd_scan_fifo_chk.sv
module kbd_scan_fifo_chk #(
    parameter int ROWS  = 8,
    parameter int DEPTH = 8,
    parameter int CNTW  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ROWS-1:0] row_drv,
    input logic            rd_en,
    input logic            rd_sel,
    input logic            clr_ovr,
    input logic            irq,
    input logic            push,
    input logic [CNTW-1:0] fifo_cnt,
    input logic            ovr
);
    assert_row_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_drv) == 1);

    assert_push_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_cnt) <= DEPTH);

    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !clr_ovr) |=> ovr);

    assert_ovr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovr && !push) |=> !ovr);

    assert_irq_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel && fifo_cnt == CNTW'(1) && !push) |=> !irq);

    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel && fifo_cnt == '0 && !push) |=> (fifo_cnt == '0));
endmodule

bind kbd_scan_fifo kbd_scan_fifo_chk #(.ROWS(ROWS), .DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_drv  (row_drv),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .clr_ovr  (clr_ovr),
    .irq      (irq),
    .push     (db_push),
    .fifo_cnt (fifo_cnt),
    .ovr      (fifo_ovr)
);

// File: tb/kbd_scan_fifo_tb.sv
module kbd_scan_fifo_tb;
    localparam int ROWS  = 8;
    localparam int COLS  = 8;
    localparam int DWELL = 4;
    localparam int SCAN  = ROWS * DWELL;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [ROWS-1:0] row_drv;
    logic [COLS-1:0] col_in;
    logic            rd_en = 1'b0;
    logic            rd_sel = 1'b0;
    logic [7:0]      rd_data;
    logic            clr_ovr = 1'b0;
    logic            irq;
    logic [63:0]     keys = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // key matrix model: a closed key ties its column to its row line
    always_comb begin
        col_in = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                if (row_drv[r] && keys[r*COLS+c]) col_in[c] = 1'b1;
    end

    kbd_scan_fifo u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_drv (row_drv),
        .col_in  (col_in),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .clr_ovr (clr_ovr),
        .irq     (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic scans(input int n);
        repeat (n * SCAN) @(negedge clk);
    endtask

    task automatic rd_status(output logic [7:0] v);
        @(negedge clk);
        rd_sel = 1'b1;
        #1 v = rd_data;
    endtask

    task automatic rd_pop(output logic [7:0] v);
        @(negedge clk);
        rd_sel = 1'b0;
        rd_en  = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en  = 1'b0;
    endtask

    task automatic tap(input int code);
        keys = 64'd1 << code;
        scans(4);
        keys = '0;
        scans(3);
    endtask

    task automatic sync_scan_start();
        do @(negedge clk); while (!row_drv[ROWS-1]);
        do @(negedge clk); while (!row_drv[0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 row during reset", int'(row_drv), 1);
        rd_status(v);
        chk("R11 status in reset", int'(v), 0);
        chk("R11 irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 row after reset", int'(row_drv), 1);

        // R1: row order and dwell
        sync_scan_start();
        for (int r = 0; r < ROWS; r++) begin
            int bad = 0;
            for (int d = 0; d < DWELL; d++) begin
                if (row_drv != (ROWS'(1) << r)) bad++;
                @(negedge clk);
            end
            chk("R1 row dwell mismatches", bad, 0);
        end
        chk("R1 wrap to row 0", int'(row_drv), 1);

        // R10: data read on empty queue
        rd_pop(v);
        chk("R10 empty data read", int'(v), 0);
        rd_status(v);
        chk("R10 count after empty read", int'(v), 0);

        // R2/R9/R6: sweep all 64 keys
        for (int k = 0; k < 64; k++) begin
            tap(k);
            rd_status(v);
            chk("R8 status one entry", int'(v), 1);
            chk("R9 irq with entry", int'(irq), 1);
            rd_pop(v);
            chk("R2 key code", int'(v), k);
            chk("R9 irq after drain", int'(irq), 0);
        end

        // R3: key closed for exactly one pass
        sync_scan_start();
        keys = 64'd1 << 27;
        sync_scan_start();
        keys = '0;
        scans(3);
        rd_status(v);
        chk("R3 single-pass press queued", int'(v), 0);

        // R4: held key reported once, again after release
        keys = 64'd1 << 5;
        scans(12);
        rd_status(v);
        chk("R4 held key count", int'(v), 1);
        keys = '0;
        scans(3);
        tap(5);
        rd_status(v);
        chk("R4 re-press count", int'(v), 2);
        rd_pop(v);
        chk("R4 first code", int'(v), 5);
        rd_pop(v);
        chk("R4 second code", int'(v), 5);

        // R5: two keys together, lower wins, then the other follows
        keys = (64'd1 << 10) | (64'd1 << 45);
        scans(4);
        rd_status(v);
        chk("R5 only one of two queued", int'(v), 1);
        keys = 64'd1 << 45;
        scans(4);
        keys = '0;
        scans(3);
        rd_status(v);
        chk("R5 second key queued", int'(v), 2);
        rd_pop(v);
        chk("R5 lower code first", int'(v), 10);
        rd_pop(v);
        chk("R5 remaining key", int'(v), 45);

        // R7/R6/R8: overrun with nine keys
        for (int i = 0; i < 9; i++) tap(20 + i);
        rd_status(v);
        chk("R7 status full with overrun", int'(v), 'h88);
        rd_status(v);
        chk("R8 status read does not pop", int'(v), 'h88);
        @(negedge clk) clr_ovr = 1'b1;
        @(negedge clk) clr_ovr = 1'b0;
        rd_status(v);
        chk("R7 clear keeps count", int'(v), 'h08);
        for (int i = 0; i < 8; i++) begin
            rd_pop(v);
            chk("R6 oldest first", int'(v), 20 + i);
        end
        rd_status(v);
        chk("R6 drained", int'(v), 0);
        chk("R9 irq low when drained", int'(irq), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule